// File: doc/BRIEF.md
# Flash Query Mode Controller

This block keeps track of which data source a flash-style device model presents on reads. It has three modes: normal array reads, an identifier (autoselect) mode, and a query mode that returns a fixed identification table. The mode changes only in response to qualified command writes. In query mode the block supplies the table word for the current read address. Array storage and the identifier data are handled elsewhere, and the `rd_src` output tells the read multiplexer which source to use.

The block also decides whether a program or erase request may go ahead for a given sector. Each sector has a stored protection bit. A write-protect input, when driven low, additionally locks the boot sectors at both ends of the sector range, whatever their stored bits say.

Top module: `qmode_ctrl`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) places the block in array mode (`rd_src` = 2'b00). With the default parameters, `qry_data` reads 0000h after reset.
- R2: A write with `wr_en` high, low data byte 98h and `wr_addr` equal to 55h puts the block into query mode (`rd_src` = 2'b10) when it is in array mode. The new mode is visible after the write's clock edge.
- R3: The same 98h at 55h write also enters query mode from autoselect mode.
- R4: In query mode, a write whose low data byte is F0h, at any address, leaves query mode. The block returns to array mode if it entered query mode from array mode, and to autoselect mode (`rd_src` = 2'b01) if it entered from autoselect.
- R5: In array mode, a write with low data byte 90h at any address enters autoselect mode. In autoselect mode, a write with low data byte F0h returns the block to array mode.
- R6: In query mode, read addresses 10h, 11h and 12h give 0051h, 0052h and 0059h on `qry_data`.
- R7: In query mode, address 13h gives 0002h, 15h gives 0040h, and 14h and 16h through 1Ah give 0000h. Any address outside 10h–1Ah gives 0000h. Outside query mode, `qry_data` is 0000h.
- R8: Some writes leave the mode unchanged: cycles with `wr_en` low, 98h written to any address other than 55h, other data bytes, and any command other than F0h while in query mode.
- R9: When `wp_n` is low, `pe_ok` is 0 for sectors 0–3 and 266–269, even if their stored protection bits are clear.
- R10: When `wp_n` is high, `pe_ok` for a boot sector is the inverse of its stored bit. For every other valid sector, `pe_ok` is the inverse of its stored bit whatever `wp_n` is. `pe_ok` is 0 when `pe_req` is low or when the sector number is 270 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Qualified command write strobe, one cycle per write |
| wr_addr | input | 12 | Command write word address |
| wr_data | input | 16 | Command write data; the low byte is the command |
| rd_addr | input | 12 | Read word address |
| wp_n | input | 1 | Write protect; low locks the boot sectors |
| prot_bits | input | 270 | Stored protection bit per sector, 1 = protected |
| pe_req | input | 1 | Program/erase request |
| pe_sector | input | 9 | Sector number targeted by the request |
| rd_src | output | 2 | Read source: 00 array, 01 autoselect, 10 query |
| qry_data | output | 16 | Query table word for `rd_addr` |
| pe_ok | output | 1 | Program/erase permitted |

## Verification
The bench builds the block with its defaults: 270 sectors, 4 boot sectors at each end, 12-bit addresses and 16-bit data. With these values the sector edges 3/4, 265/266 and 269/270 can be probed directly, and the 9-bit sector field can carry the out-of-range value 270. Mode tests enter query mode along both paths, so the return-to-origin rule on reset is checked in each direction. The table is read at its first and last addresses and just outside them.

// File: rtl/qmode_pkg.sv
// Shared types and command codes for the query mode controller.
// Assumes commands are carried in the low byte of the write data.
package qmode_pkg;
    typedef enum logic [1:0] {
        MODE_ARRAY   = 2'b00,
        MODE_AUTOSEL = 2'b01,
        MODE_QUERY   = 2'b10
    } mode_t;

    localparam logic [7:0] CMD_QUERY   = 8'h98;
    localparam logic [7:0] CMD_AUTOSEL = 8'h90;
    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] QUERY_ADDR  = 8'h55;
endpackage

// File: rtl/qmode_fsm.sv
// Mode state machine: array, autoselect and query modes.
// Remembers where query mode was entered from so a reset command returns there.
// Assumes wr_en is already qualified and lasts one cycle per write.
module qmode_fsm
    import qmode_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output mode_t         mode
);
    localparam logic [AW-1:0] Q_ADDR = AW'(QUERY_ADDR);

    mode_t mode_q, mode_d;
    logic  from_as_q, from_as_d;
    logic [7:0] cmd;
    logic is_query_cmd;

    assign cmd          = wr_data[7:0];
    assign is_query_cmd = (cmd == CMD_QUERY) && (wr_addr == Q_ADDR);

    // Next-mode decode from the current mode and the command byte.
    always_comb begin
        mode_d    = mode_q;
        from_as_d = from_as_q;
        if (wr_en) begin
            unique case (mode_q)
                MODE_ARRAY: begin
                    if (is_query_cmd) begin
                        mode_d    = MODE_QUERY;
                        from_as_d = 1'b0;
                    end else if (cmd == CMD_AUTOSEL) begin
                        mode_d = MODE_AUTOSEL;
                    end
                end
                MODE_AUTOSEL: begin
                    if (is_query_cmd) begin
                        mode_d    = MODE_QUERY;
                        from_as_d = 1'b1;
                    end else if (cmd == CMD_RESET) begin
                        mode_d = MODE_ARRAY;
                    end
                end
                MODE_QUERY: begin
                    if (cmd == CMD_RESET)
                        mode_d = from_as_q ? MODE_AUTOSEL : MODE_ARRAY;
                end
                default: mode_d = MODE_ARRAY;
            endcase
        end
    end

    // Mode and origin registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_ARRAY;
            from_as_q <= 1'b0;
        end else begin
            mode_q    <= mode_d;
            from_as_q <= from_as_d;
        end
    end

    assign mode = mode_q;

    // R2
    enter_from_array_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_query_cmd && mode_q == MODE_ARRAY) |=> (mode_q == MODE_QUERY));
    // R3
    enter_from_autosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_query_cmd && mode_q == MODE_AUTOSEL) |=> (mode_q == MODE_QUERY));
    // R4
    query_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cmd == CMD_RESET && mode_q == MODE_QUERY)
        |=> (mode_q == ($past(from_as_q) ? MODE_AUTOSEL : MODE_ARRAY)));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mode_q));
endmodule

// File: rtl/qmode_table.sv
// Query identification table lookup.
// Returns zero outside query mode and for addresses outside the table.
module qmode_table #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          query_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] data
);
    // Table lookup; entries not listed are zero.
    always_comb begin
        data = '0;
        if (query_en) begin
            case (rd_addr)
                AW'(8'h10): data = DW'(16'h0051);
                AW'(8'h11): data = DW'(16'h0052);
                AW'(8'h12): data = DW'(16'h0059);
                AW'(8'h13): data = DW'(16'h0002);
                AW'(8'h15): data = DW'(16'h0040);
                default:    data = '0;
            endcase
        end
    end

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !query_en |-> (data == '0));
endmodule

// File: rtl/qmode_protect.sv
// Program/erase permit. The boot sectors at both ends of the range are
// locked when wp_n is low; all sectors otherwise follow their stored bit.
// Assumes NUM_SECT >= 2*BOOT_N.
module qmode_protect #(
    parameter int NUM_SECT = 270,
    parameter int BOOT_N   = 4,
    parameter int SW       = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wp_n,
    input  logic [NUM_SECT-1:0] prot_bits,
    input  logic                pe_req,
    input  logic [SW-1:0]       pe_sector,
    output logic                pe_ok
);
    localparam logic [SW-1:0] SECT_END = SW'(NUM_SECT);
    localparam logic [SW-1:0] LOW_END  = SW'(BOOT_N);
    localparam logic [SW-1:0] HI_START = SW'(NUM_SECT - BOOT_N);

    logic in_range, is_boot, stored;

    // Classify the target sector and fetch its stored bit.
    always_comb begin
        in_range = pe_sector < SECT_END;
        is_boot  = in_range && ((pe_sector < LOW_END) || (pe_sector >= HI_START));
        stored   = in_range ? prot_bits[pe_sector] : 1'b1;
    end

    // Combine request, stored bit and hardware lock.
    always_comb begin
        pe_ok = pe_req && in_range && !stored && !(is_boot && !wp_n);
    end

    // R9
    boot_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && is_boot) |-> !pe_ok);
    // R10
    stored_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_range && prot_bits[pe_sector]) |-> !pe_ok);
endmodule

// File: rtl/qmode_ctrl.sv
// Top of the query mode controller: mode FSM, query table and
// program/erase permit. Read source select is the registered mode.
module qmode_ctrl
    import qmode_pkg::*;
#(
    parameter int AW       = 12,
    parameter int DW       = 16,
    parameter int NUM_SECT = 270,
    parameter int BOOT_N   = 4,
    parameter int SW       = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [AW-1:0]       wr_addr,
    input  logic [DW-1:0]       wr_data,
    input  logic [AW-1:0]       rd_addr,
    input  logic                wp_n,
    input  logic [NUM_SECT-1:0] prot_bits,
    input  logic                pe_req,
    input  logic [SW-1:0]       pe_sector,
    output logic [1:0]          rd_src,
    output logic [DW-1:0]       qry_data,
    output logic                pe_ok
);
    mode_t mode;

    qmode_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .mode(mode)
    );

    qmode_table #(.AW(AW), .DW(DW)) u_table (
        .clk(clk), .rst_n(rst_n), .query_en(mode == MODE_QUERY),
        .rd_addr(rd_addr), .data(qry_data)
    );

    qmode_protect #(.NUM_SECT(NUM_SECT), .BOOT_N(BOOT_N), .SW(SW)) u_prot (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .prot_bits(prot_bits),
        .pe_req(pe_req), .pe_sector(pe_sector), .pe_ok(pe_ok)
    );

    assign rd_src = mode;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (rd_src == 2'b00));
endmodule

// File: tb/qmode_ctrl_test.sv
module qmode_ctrl_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [11:0]  wr_addr = '0;
    logic [15:0]  wr_data = '0;
    logic [11:0]  rd_addr = '0;
    logic         wp_n = 1'b1;
    logic [269:0] prot_bits = '0;
    logic         pe_req = 1'b0;
    logic [8:0]   pe_sector = '0;
    logic [1:0]   rd_src;
    logic [15:0]  qry_data;
    logic         pe_ok;
    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    qmode_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .wp_n(wp_n),
        .prot_bits(prot_bits), .pe_req(pe_req), .pe_sector(pe_sector),
        .rd_src(rd_src), .qry_data(qry_data), .pe_ok(pe_ok)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One command write; the result is sampled at the following negedge.
    task automatic cmd_write(logic [11:0] a, logic [15:0] d);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(string req, logic [11:0] a, logic [15:0] exp);
        rd_addr = a;
        #1;
        check(req, 32'(qry_data), 32'(exp));
    endtask

    task automatic pe_check(string req, logic [8:0] s, logic exp);
        pe_sector = s;
        #1;
        check(req, 32'(pe_ok), 32'(exp));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rd_src after reset", 32'(rd_src), 32'd0);
        rd_check("R1 qry_data after reset", 12'h010, 16'h0000);
    endtask

    task automatic t_query_from_array;
        cmd_write(12'h055, 16'h0098);
        check("R2 enter query", 32'(rd_src), 32'd2);
        rd_check("R6 10h", 12'h010, 16'h0051);
        rd_check("R6 11h", 12'h011, 16'h0052);
        rd_check("R6 12h", 12'h012, 16'h0059);
        rd_check("R7 13h", 12'h013, 16'h0002);
        rd_check("R7 14h", 12'h014, 16'h0000);
        rd_check("R7 15h", 12'h015, 16'h0040);
        rd_check("R7 1Ah", 12'h01A, 16'h0000);
        rd_check("R7 0Fh outside", 12'h00F, 16'h0000);
        rd_check("R7 1Bh outside", 12'h01B, 16'h0000);
        cmd_write(12'h000, 16'h0090);
        check("R8 90h ignored in query", 32'(rd_src), 32'd2);
        cmd_write(12'h123, 16'h00F0);
        check("R4 exit to array", 32'(rd_src), 32'd0);
        rd_check("R7 zero outside query", 12'h010, 16'h0000);
    endtask

    task automatic t_ignored;
        cmd_write(12'h056, 16'h0098);
        check("R8 wrong address", 32'(rd_src), 32'd0);
        cmd_write(12'h055, 16'h0097);
        check("R8 wrong data", 32'(rd_src), 32'd0);
        @(negedge clk);
        wr_addr = 12'h055; wr_data = 16'h0098; wr_en = 1'b0;
        @(negedge clk);
        check("R8 wr_en low", 32'(rd_src), 32'd0);
    endtask

    task automatic t_autosel;
        cmd_write(12'h000, 16'h0090);
        check("R5 enter autoselect", 32'(rd_src), 32'd1);
        rd_check("R7 zero in autoselect", 12'h010, 16'h0000);
        cmd_write(12'h055, 16'h0098);
        check("R3 query from autoselect", 32'(rd_src), 32'd2);
        rd_check("R6 10h via autoselect", 12'h010, 16'h0051);
        cmd_write(12'h7AA, 16'h00F0);
        check("R4 exit to autoselect", 32'(rd_src), 32'd1);
        cmd_write(12'h000, 16'h00F0);
        check("R5 autoselect to array", 32'(rd_src), 32'd0);
    endtask

    task automatic t_protect;
        prot_bits = '0; pe_req = 1'b1; wp_n = 1'b0;
        pe_check("R9 sector 0 locked", 9'd0, 1'b0);
        pe_check("R9 sector 3 locked", 9'd3, 1'b0);
        pe_check("R9 sector 266 locked", 9'd266, 1'b0);
        pe_check("R9 sector 269 locked", 9'd269, 1'b0);
        pe_check("R10 sector 4 free", 9'd4, 1'b1);
        pe_check("R10 sector 265 free", 9'd265, 1'b1);
        pe_check("R10 sector 270 invalid", 9'd270, 1'b0);
        wp_n = 1'b1;
        pe_check("R10 sector 0 unlocked", 9'd0, 1'b1);
        pe_check("R10 sector 269 unlocked", 9'd269, 1'b1);
        prot_bits[2] = 1'b1;
        pe_check("R10 stored bit boot", 9'd2, 1'b0);
        prot_bits[100] = 1'b1;
        pe_check("R10 stored bit middle", 9'd100, 1'b0);
        wp_n = 1'b0;
        pe_check("R10 middle ignores wp", 9'd101, 1'b1);
        pe_req = 1'b0;
        pe_check("R10 no request", 9'd101, 1'b0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_query_from_array();
                t_ignored();
                t_autosel();
                t_protect();
            end
            begin
                repeat (5000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule